// File: doc/BRIEF.md
# Interleaved Block Read Controller

This block fetches one cache line of consecutive words from a bank of memory modules whose addresses are interleaved on the low-order bits. Word `a` of memory sits in module `a mod NUM_MODS`, at position `a >> log2(NUM_MODS)` inside that module. Each module is modelled as an address buffer register, a data buffer register and a small countdown that stands for the module's access time: `T_FIRST` cycles for the first word after an address is loaded, and `T_NEXT` cycles for each following word. The next fetch overlaps the cycle in which the previous word is taken out of the data buffer.

A requester presents a word address with `req_valid` while the controller is idle. The controller rounds the address down to the block boundary and sends the in-module address to each module in turn, one per cycle, over a single shared bus. It then reads the data buffers back over the same bus in ascending word order. Each word appears on a registered output stream with its index, and `blk_done` marks the final word. With four modules, an 8-word block and 6/4-cycle module timing, the last word is out 15 cycles after the request is taken. A one-module build of the same RTL needs 36.

The modules hold no written data. The word stored at address `a` is the fixed pattern `(a * 32'h9E3779B1) mod 2^32`, so the data on the stream shows which address was fetched.

Top module: `ilv_block_reader`

## Requirements
- R1: Word index i of a block carries the pattern of address (aligned base + i), where the pattern of address a is the low 32 bits of a multiplied by 32'h9E3779B1.
- R2: The request address is rounded down to a multiple of BLOCK_WORDS (8): its low three bits are ignored.
- R3: Every accepted request yields exactly eight `word_valid` pulses, with `word_idx` running 0, 1, ..., 7 in that order.
- R4: With four modules and 6/4-cycle timing, word i is shown on the outputs after clock edge 8+i, counting the edge that accepts the request as edge 0. The last word therefore follows edge 15.
- R5: `blk_done` is high only in the cycle that shows word index 7, and is low in the cycle after.
- R6: With one module (NUM_MODS = 1), word i is shown after edge 8+4i, so the block completes after edge 36.
- R7: A `req_valid` pulse that arrives while a block is in progress has no effect: the running stream keeps its addresses, and no extra words follow it.
- R8: While `rst_n` is low at a clock edge, the outputs clear to zero. A reset during a transfer abandons it, and no words appear afterwards until a new request arrives.
- R9: The shared bus carries at most one operation per cycle, either an address load into one module or a data-buffer read from one module. Addresses go to modules 0..NUM_MODS-1 in successive cycles.
- R10: A new request is accepted in the cycle right after the one that shows `blk_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Block read request, taken only while idle |
| req_addr | input | ADDR_W (16) | Word address inside the wanted block |
| word_valid | output | 1 | A block word is on `word_data` this cycle |
| word_idx | output | log2(BLOCK_WORDS) (3) | Position of the word within the block |
| word_data | output | DATA_W (32) | Word read from the modules |
| blk_done | output | 1 | High with the last word of the block |

## Verification
The properties assume that the timing parameters are legal: `NUM_MODS` is a power of two that divides `BLOCK_WORDS`, and `T_NEXT` is at least 2. They also assume that reset is applied once before any traffic. Given those, they make no assumption about request timing, because requests that arrive while a block is running are dropped by design. The bench builds only legal configurations, four modules and one module. It deliberately sends requests during a transfer and pulses reset in the middle of a block, so the dropping path and the recovery path both run under the same properties.

// File: rtl/ilv_pkg.sv
// Shared definitions for the interleaved block reader.
// Assumes nothing beyond a 32-bit address view for the content pattern.
package ilv_pkg;

    localparam logic [31:0] PAT_MUL = 32'h9E3779B1;

    // Fixed content of memory word at address a (the modules are read-only models).
    function automatic logic [31:0] word_pattern(input logic [31:0] a);
        return a * PAT_MUL;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
// One memory module model: address buffer register, data buffer register and
// an access-time countdown. A load starts the first fetch (T_FIRST cycles);
// reading the data buffer starts the next fetch (T_NEXT cycles, the read cycle
// included) until WPM words have been delivered.
// Assumes T_NEXT >= 2, and that ld_i and rd_i are never high together.
module ilv_bank #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_MODS = 4,
    parameter int MOD_ID   = 0,
    parameter int WPM      = 2,
    parameter int T_FIRST  = 6,
    parameter int T_NEXT   = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ld_i,
    input  logic [ADDR_W-$clog2(NUM_MODS)-1:0]    ld_addr_i,
    input  logic                                  rd_i,
    output logic                                  full_o,
    output logic [DATA_W-1:0]                     dbr_o
);
    import ilv_pkg::*;

    localparam int K      = $clog2(NUM_MODS);
    localparam int IN_W   = ADDR_W - K;
    localparam int TMAX   = (T_FIRST > T_NEXT) ? T_FIRST : T_NEXT;
    localparam int CNT_W  = $clog2(TMAX + 1);
    localparam int LEFT_W = $clog2(WPM + 1);

    logic [IN_W-1:0]   abr;
    logic [CNT_W-1:0]  cnt;
    logic [LEFT_W-1:0] left;
    logic              fetching;
    logic [ADDR_W-1:0] full_addr;

    // Rebuild the memory-wide address of the word held in the address buffer.
    assign full_addr = (ADDR_W'(abr) << K) | ADDR_W'(MOD_ID);

    // Address load, overlapped next-word fetch and access-time countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abr      <= '0;
            cnt      <= '0;
            left     <= '0;
            fetching <= 1'b0;
            full_o   <= 1'b0;
            dbr_o    <= '0;
        end else if (ld_i) begin
            abr      <= ld_addr_i;
            cnt      <= CNT_W'(T_FIRST);
            left     <= LEFT_W'(WPM - 1);
            fetching <= 1'b1;
            full_o   <= 1'b0;
        end else if (rd_i) begin
            full_o <= 1'b0;
            if (left != '0) begin
                abr      <= abr + IN_W'(1);
                cnt      <= CNT_W'(T_NEXT - 1);
                left     <= left - LEFT_W'(1);
                fetching <= 1'b1;
            end
        end else if (fetching) begin
            if (cnt == CNT_W'(1)) begin
                dbr_o    <= DATA_W'(word_pattern(32'(full_addr)));
                full_o   <= 1'b1;
                fetching <= 1'b0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/ilv_issue.sv
// Address issue sequencer: after a start, drives one module load per cycle on
// the shared bus, module 0 first, each with the block's in-module address.
// Assumes start_i arrives only while the controller is idle.
module ilv_issue #(
    parameter int ADDR_W   = 16,
    parameter int NUM_MODS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [ADDR_W-1:0]                   base_i,
    output logic [NUM_MODS-1:0]                 ld_o,
    output logic [ADDR_W-$clog2(NUM_MODS)-1:0]  ld_addr_o
);
    localparam int K     = $clog2(NUM_MODS);
    localparam int IN_W  = ADDR_W - K;
    localparam int IDX_W = (K > 0) ? K : 1;

    logic             on;
    logic [IDX_W-1:0] idx;
    logic [IN_W-1:0]  blk;

    // Walk the module index once per start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on  <= 1'b0;
            idx <= '0;
            blk <= '0;
        end else if (start_i) begin
            on  <= 1'b1;
            idx <= '0;
            blk <= IN_W'(base_i >> K);
        end else if (on) begin
            if (idx == IDX_W'(NUM_MODS - 1)) on <= 1'b0;
            else                             idx <= idx + IDX_W'(1);
        end
    end

    // Decode the current index into a single module load strobe.
    for (genvar m = 0; m < NUM_MODS; m++) begin : g_ld
        assign ld_o[m] = on && (idx == IDX_W'(m));
    end

    assign ld_addr_o = blk;

endmodule

// File: rtl/ilv_collect.sv
// Data collector: reads the data buffers in ascending word order, one read per
// cycle when the bus is free and the owning module's buffer is full, and
// registers each word onto the output stream.
// Assumes NUM_MODS is a power of two dividing WORDS.
module ilv_collect #(
    parameter int DATA_W   = 32,
    parameter int NUM_MODS = 4,
    parameter int WORDS    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic                              bus_busy_i,
    input  logic [NUM_MODS-1:0]               full_i,
    input  logic [NUM_MODS-1:0][DATA_W-1:0]   dbr_i,
    output logic [NUM_MODS-1:0]               rd_o,
    output logic                              busy_o,
    output logic                              word_valid_o,
    output logic [$clog2(WORDS)-1:0]          word_idx_o,
    output logic [DATA_W-1:0]                 word_data_o,
    output logic                              done_o
);
    localparam int K     = $clog2(NUM_MODS);
    localparam int SEL_W = (K > 0) ? K : 1;
    localparam int OFF_W = $clog2(WORDS);

    logic             active;
    logic [OFF_W-1:0] rd_idx;
    logic [SEL_W-1:0] sel;
    logic             rd_go;
    logic             last;

    assign sel   = SEL_W'(32'(rd_idx) % NUM_MODS);
    assign rd_go = active && !bus_busy_i && full_i[sel];
    assign last  = (rd_idx == OFF_W'(WORDS - 1));

    // Route the single read strobe to the module owning the next word.
    for (genvar m = 0; m < NUM_MODS; m++) begin : g_rd
        assign rd_o[m] = rd_go && (sel == SEL_W'(m));
    end

    // Track progress through the block and register the output stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active       <= 1'b0;
            rd_idx       <= '0;
            word_valid_o <= 1'b0;
            word_idx_o   <= '0;
            word_data_o  <= '0;
            done_o       <= 1'b0;
        end else begin
            word_valid_o <= rd_go;
            done_o       <= rd_go && last;
            if (start_i) begin
                active <= 1'b1;
                rd_idx <= '0;
            end else if (rd_go) begin
                word_idx_o  <= rd_idx;
                word_data_o <= dbr_i[sel];
                rd_idx      <= rd_idx + OFF_W'(1);
                if (last) active <= 1'b0;
            end
        end
    end

    assign busy_o = active;

endmodule

// File: rtl/ilv_block_reader.sv
// Top of the interleaved block reader: takes a block request when idle,
// aligns it, issues module addresses over the shared bus, then collects the
// words in order. Issue has the bus before any data read.
// Assumes NUM_MODS is a power of two dividing BLOCK_WORDS, and T_NEXT >= 2.
module ilv_block_reader #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int NUM_MODS    = 4,
    parameter int BLOCK_WORDS = 8,
    parameter int T_FIRST     = 6,
    parameter int T_NEXT      = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [ADDR_W-1:0]               req_addr,
    output logic                            word_valid,
    output logic [$clog2(BLOCK_WORDS)-1:0]  word_idx,
    output logic [DATA_W-1:0]               word_data,
    output logic                            blk_done
);
    localparam int K     = $clog2(NUM_MODS);
    localparam int IN_W  = ADDR_W - K;
    localparam int WPM   = BLOCK_WORDS / NUM_MODS;

    logic                            accept;
    logic                            coll_busy;
    logic [ADDR_W-1:0]               aligned;
    logic [NUM_MODS-1:0]             bank_ld;
    logic [NUM_MODS-1:0]             bank_rd;
    logic [NUM_MODS-1:0]             bank_full;
    logic [NUM_MODS-1:0][DATA_W-1:0] bank_dbr;
    logic [IN_W-1:0]                 blk_addr;

    assign aligned = req_addr & ~ADDR_W'(BLOCK_WORDS - 1);
    assign accept  = req_valid && !coll_busy;

    ilv_issue #(
        .ADDR_W   (ADDR_W),
        .NUM_MODS (NUM_MODS)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept),
        .base_i    (aligned),
        .ld_o      (bank_ld),
        .ld_addr_o (blk_addr)
    );

    for (genvar m = 0; m < NUM_MODS; m++) begin : g_bank
        ilv_bank #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .NUM_MODS (NUM_MODS),
            .MOD_ID   (m),
            .WPM      (WPM),
            .T_FIRST  (T_FIRST),
            .T_NEXT   (T_NEXT)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_i      (bank_ld[m]),
            .ld_addr_i (blk_addr),
            .rd_i      (bank_rd[m]),
            .full_o    (bank_full[m]),
            .dbr_o     (bank_dbr[m])
        );
    end

    ilv_collect #(
        .DATA_W   (DATA_W),
        .NUM_MODS (NUM_MODS),
        .WORDS    (BLOCK_WORDS)
    ) u_collect (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept),
        .bus_busy_i   (|bank_ld),
        .full_i       (bank_full),
        .dbr_i        (bank_dbr),
        .rd_o         (bank_rd),
        .busy_o       (coll_busy),
        .word_valid_o (word_valid),
        .word_idx_o   (word_idx),
        .word_data_o  (word_data),
        .done_o       (blk_done)
    );

endmodule

// File: rtl/ilv_block_reader_chk.sv
// Property checker for ilv_block_reader, attached by bind below.
// Assumes reset is applied before the first request.
module ilv_block_reader_chk #(
    parameter int NUM_MODS    = 4,
    parameter int BLOCK_WORDS = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            word_valid,
    input logic [$clog2(BLOCK_WORDS)-1:0]  word_idx,
    input logic                            blk_done,
    input logic [NUM_MODS-1:0]             bank_ld,
    input logic [NUM_MODS-1:0]             bank_rd
);
    localparam int OFF_W = $clog2(BLOCK_WORDS);

    logic [OFF_W-1:0] exp_idx;

    // Count the words seen so far in the current block.
    always_ff @(posedge clk) begin
        if (!rst_n)                 exp_idx <= '0;
        else if (word_valid && blk_done) exp_idx <= '0;
        else if (word_valid)        exp_idx <= exp_idx + OFF_W'(1);
    end

    // R3
    idx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> word_idx == exp_idx);

    // R9
    bus_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_ld, bank_rd}));

    // R5
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> word_valid && word_idx == OFF_W'(BLOCK_WORDS - 1));

    // R5
    done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !word_valid);

endmodule

bind ilv_block_reader ilv_block_reader_chk #(
    .NUM_MODS    (NUM_MODS),
    .BLOCK_WORDS (BLOCK_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_idx   (word_idx),
    .blk_done   (blk_done),
    .bank_ld    (bank_ld),
    .bank_rd    (bank_rd)
);

// File: tb/ilv_block_reader_tb.sv
// Self-checking bench: vector table walked by one loop, then directed tests.
module ilv_block_reader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        word_valid;
    logic [2:0]  word_idx;
    logic [31:0] word_data;
    logic        blk_done;

    logic        req1_valid = 1'b0;
    logic [15:0] req1_addr = '0;
    logic        s_valid;
    logic [2:0]  s_idx;
    logic [31:0] s_data;
    logic        s_done;

    always #2 clk = ~clk;

    ilv_block_reader u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .word_valid(word_valid), .word_idx(word_idx), .word_data(word_data),
        .blk_done(blk_done)
    );

    ilv_block_reader #(.NUM_MODS(1)) u_dut_single (
        .clk(clk), .rst_n(rst_n), .req_valid(req1_valid), .req_addr(req1_addr),
        .word_valid(s_valid), .word_idx(s_idx), .word_data(s_data),
        .blk_done(s_done)
    );

    localparam int NV = 6;
    localparam logic [15:0] VEC_REQ  [NV] = '{16'h0000, 16'h0008, 16'h1230, 16'hFFF8, 16'h0013, 16'h7ABF};
    localparam logic [15:0] VEC_BASE [NV] = '{16'h0000, 16'h0008, 16'h1230, 16'hFFF8, 16'h0010, 16'h7AB8};

    int n_checks = 0;
    int n_fail   = 0;
    int ecount   = 0;
    int e0       = 0;
    int e1       = 0;
    bit finished = 1'b0;

    int          got_seen [8];
    int          got_edge [8];
    logic [31:0] got_data [8];
    int          done_edge, done_cnt, n_valid;

    int          s_edge [8];
    logic [31:0] s_word [8];
    int          s_done_edge;

    function automatic logic [31:0] pat(input logic [15:0] a);
        return {16'h0, a} * 32'h9E3779B1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) ecount <= ecount + 1;

    // Record the main stream, relative to the accept edge.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            got_seen[word_idx] = got_seen[word_idx] + 1;
            got_edge[word_idx] = ecount - e0;
            got_data[word_idx] = word_data;
            n_valid = n_valid + 1;
        end
        if (rst_n && blk_done) begin
            done_edge = ecount - e0;
            done_cnt  = done_cnt + 1;
        end
        if (rst_n && s_valid) begin
            s_edge[s_idx] = ecount - e1;
            s_word[s_idx] = s_data;
        end
        if (rst_n && s_done) s_done_edge = ecount - e1;
    end

    task automatic clear_rec();
        for (int i = 0; i < 8; i++) begin
            got_seen[i] = 0; got_edge[i] = -1; got_data[i] = '0;
        end
        done_edge = -1; done_cnt = 0; n_valid = 0;
    endtask

    // Issue one block read; optionally inject a second request at cycle inj.
    task automatic run_block(input logic [15:0] a, input int inj, input logic [15:0] inj_addr);
        clear_rec();
        req_valid = 1'b1; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        e0 = ecount;
        req_valid = 1'b0;
        for (int k = 1; k < 40 && done_cnt == 0; k++) begin
            if (k == inj) begin req_valid = 1'b1; req_addr = inj_addr; end
            else req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic check_block(input logic [15:0] base, input string tag);
        for (int i = 0; i < 8; i++) begin
            check(got_seen[i] == 1, "R3", {tag, " word seen once"}, got_seen[i], 1);
            check(got_data[i] == pat(base + 16'(i)), "R1", {tag, " word data"}, got_data[i], pat(base + 16'(i)));
            check(got_edge[i] == 8 + i, "R4", {tag, " word edge"}, got_edge[i], 8 + i);
        end
        check(done_cnt == 1 && done_edge == 15, "R5", {tag, " done edge"}, done_edge, 15);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        clear_rec();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        check(word_valid == 0 && blk_done == 0 && word_data == 0, "R8", "outputs in reset",
              {word_valid, blk_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector loop: R1, R2, R3, R4, R5, and R10 through back-to-back requests.
        for (int v = 0; v < NV; v++) begin
            run_block(VEC_REQ[v], -1, 16'h0);
            check_block(VEC_BASE[v], (VEC_REQ[v] != VEC_BASE[v]) ? "R2 misaligned" : "vector");
        end

        // R10: next request driven in the cycle right after blk_done, first word at edge 8.
        run_block(16'h0200, -1, 16'h0);
        run_block(16'h0300, -1, 16'h0);
        check(got_edge[0] == 8, "R10", "accept right after done", got_edge[0], 8);
        // R9: one bus operation per cycle shows as words on consecutive edges.
        check(got_edge[7] - got_edge[0] == 7, "R9", "one read per cycle", got_edge[7] - got_edge[0], 7);

        // R7: request during a transfer is ignored.
        run_block(16'h0040, 3, 16'h0100);
        check_block(16'h0040, "R7 busy");
        repeat (30) @(negedge clk);
        check(n_valid == 8, "R7", "no extra words", n_valid, 8);

        // R8: reset during a transfer abandons it.
        clear_rec();
        req_valid = 1'b1; req_addr = 16'h0500;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(word_valid == 0 && blk_done == 0, "R8", "outputs during reset", word_valid, 0);
        rst_n = 1'b1;
        clear_rec();
        repeat (25) @(negedge clk);
        check(n_valid == 0, "R8", "no words after abandoned block", n_valid, 0);
        run_block(16'h0600, -1, 16'h0);
        check_block(16'h0600, "R8 recovery");

        // R6: single-module configuration.
        for (int i = 0; i < 8; i++) begin s_edge[i] = -1; s_word[i] = '0; end
        s_done_edge = -1;
        req1_valid = 1'b1; req1_addr = 16'h0020;
        @(posedge clk);
        @(negedge clk);
        e1 = ecount;
        req1_valid = 1'b0;
        repeat (45) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            check(s_edge[i] == 8 + 4 * i, "R6", "single module word edge", s_edge[i], 8 + 4 * i);
            check(s_word[i] == pat(16'h0020 + 16'(i)), "R6", "single module data", s_word[i], pat(16'h0020 + 16'(i)));
        end
        check(s_done_edge == 36, "R6", "single module done edge", s_done_edge, 36);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule